// File: doc/BRIEF.md
# Dual-Rail Soft-Start and Fault Sequencer

This block is the digital sequencer for a regulator with two outputs: a switching stage with high-side and low-side gates, and a linear stage with one pass-device drive. It advances on a single-cycle tick from the oscillator. It starts only when a hysteretic supply-good flag and an enable input are both high. It then raises two reference codes as staircases from zero to full scale. The switching code reaches full scale a fixed number of steps before the linear code does.

Comparator flags for over-current, switching under-voltage and linear under-voltage come in as logic levels. When one of them trips, the block turns off every gate, forces both codes to zero and records which fault occurred. The fault stays latched until the supply drops or enable goes low and then high again. Either of those events makes the next soft-start begin from code zero. Under-voltage on an output is not checked until that output's ramp has reached full scale, so the low feedback level during start-up cannot trip it.

Top module: `dual_rail_sequencer`

## Requirements
- R1: Reset value: both codes 0, all gate enables 0 and fault_flags 0. `supply_ok`, `enable`, `oc_trip`, `uv_sw_trip` and `uv_lin_trip` each pass through a two-flop synchronizer. A change on one of these ports shows at the outputs after the third rising clock edge.
- R2: A soft-start begins only when the synchronized `supply_ok` and `enable` are both high. At that point both codes are 0.
- R3: While ramping, `sw_ref` rises by exactly 1 after every STEP_CYCLES (32) clock edges on which `osc_tick` is high. Edges with `osc_tick` low are not counted. The code climbs from 0 to NUM_STEPS (40) and then holds.
- R4: `lin_ref` stays 0 for the first LEAD_STEPS (10) steps and then equals `sw_ref` − LEAD_STEPS. It reaches NUM_STEPS exactly LEAD_STEPS×STEP_CYCLES ticks (320) after `sw_ref` does.
- R5: `hs_gate_en`, `ls_gate_en` and `lin_drv_en` are 1 while ramping or running. In every other state they are 0 and both codes are 0.
- R6: If the synchronized `oc_trip` is high while ramping or running, the block enters the fault state. Gates and codes go to 0 and fault_flags bit 0 is set.
- R7: A switching under-voltage (fault_flags bit 1) trips only once `sw_ref` has reached NUM_STEPS. Before that, `uv_sw_trip` has no effect.
- R8: A linear under-voltage (fault_flags bit 2) trips only once `lin_ref` has reached NUM_STEPS. Before that, `uv_lin_trip` has no effect.
- R9: A fault is latched. Outputs stay off and the flags hold while supply and enable stay high, even after the comparator inputs return low.
- R10: When enable goes low, the block turns off. A fault code is kept while enable is low. An enable low-to-high transition clears the flags and restarts the ramp from 0.
- R11: When supply_ok goes low, the block turns off and clears fault_flags. When the supply returns with enable high, the ramp restarts from 0.
- R12: Trips that occur on the same clock edge set all of their flag bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Single-cycle oscillator tick, synchronous to clk |
| supply_ok | input | 1 | Hysteretic supply-good flag |
| enable | input | 1 | Enable (low = shutdown) |
| oc_trip | input | 1 | Over-current comparator flag |
| uv_sw_trip | input | 1 | Switching feedback under-voltage flag |
| uv_lin_trip | input | 1 | Linear feedback under-voltage flag |
| sw_ref | output | 6 | Switching output reference code |
| lin_ref | output | 6 | Linear output reference code |
| hs_gate_en | output | 1 | High-side gate enable of switching stage |
| ls_gate_en | output | 1 | Low-side gate enable of switching stage |
| lin_drv_en | output | 1 | Linear pass-device drive enable |
| fault_flags | output | 3 | Latched faults: bit0 over-current, bit1 switching UV, bit2 linear UV |

## Verification
The bench drives an under-voltage flag before each ramp has finished and expects no trip. A design without the mask would shut down during every start-up. It times the gap between the two ramps finishing, and the gap between two steps when ticks come only every third cycle. These measurements expose an off-by-one step length and a step counter that counts clock edges instead of ticks. It checks that a one-cycle over-current pulse stays latched, that the fault code survives enable going low but not a supply drop, and that simultaneous trips report every bit. A design that retried after a fault, or cleared the fault on the wrong event, would disagree with the cycle model.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_RAMP  = 2'd1,
      ST_RUN   = 2'd2,
      ST_FAULT = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic uv_lin;
      logic uv_sw;
      logic oc;
   } trip_t;
endpackage

// File: rtl/seqr_sync_bank.sv
module seqr_sync_bank #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("seqr_sync_bank: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[STAGES-2:0], d[b]};
      end
      assign q[b] = sr[STAGES-1];
   end
endmodule

// File: rtl/seqr_ramp_gen.sv
module seqr_ramp_gen #(
   parameter int NUM_STEPS   = 40,
   parameter int LEAD_STEPS  = 10,
   parameter int STEP_CYCLES = 32,
   parameter int CODE_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   output logic [CODE_W-1:0] sw_code,
   output logic [CODE_W-1:0] lin_code,
   output logic              sw_done,
   output logic              lin_done
);
   localparam int TOTAL = NUM_STEPS + LEAD_STEPS;
   localparam int K_W   = $clog2(TOTAL + 1);
   localparam int T_W   = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [K_W-1:0]    K_NUM   = K_W'(NUM_STEPS);
   localparam logic [K_W-1:0]    K_LEAD  = K_W'(LEAD_STEPS);
   localparam logic [K_W-1:0]    K_TOTAL = K_W'(TOTAL);
   localparam logic [T_W-1:0]    T_LAST  = T_W'(STEP_CYCLES - 1);
   localparam logic [CODE_W-1:0] C_NUM   = CODE_W'(NUM_STEPS);

   logic [K_W-1:0] step_q;
   logic [T_W-1:0] dwell_q;

   // step_q counts staircase steps over both ramps; dwell_q counts ticks inside a step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         dwell_q <= '0;
      end else if (restart) begin
         step_q  <= '0;
         dwell_q <= '0;
      end else if (advance) begin
         if (dwell_q == T_LAST) begin
            dwell_q <= '0;
            if (step_q != K_TOTAL) step_q <= step_q + 1'b1;
         end else begin
            dwell_q <= dwell_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (step_q >= K_NUM) sw_code = C_NUM;
      else                 sw_code = CODE_W'(step_q);
   end

   if (LEAD_STEPS == 0) begin : g_no_lead
      assign lin_code = sw_code;
   end else begin : g_lead
      always_comb begin
         if (step_q <= K_LEAD) lin_code = '0;
         else                  lin_code = CODE_W'(step_q - K_LEAD);
      end
   end

   assign sw_done  = (step_q >= K_NUM);
   assign lin_done = (step_q == K_TOTAL);
endmodule

// File: rtl/seqr_fault_mon.sv
module seqr_fault_mon
   import seqr_pkg::*;
(
   input  logic  armed,
   input  logic  oc_s,
   input  logic  uv_sw_s,
   input  logic  uv_lin_s,
   input  logic  sw_done,
   input  logic  lin_done,
   output trip_t trips,
   output logic  any_trip
);
   // under-voltage on each rail stays masked until that rail's ramp is complete
   always_comb begin
      trips.oc     = armed & oc_s;
      trips.uv_sw  = armed & sw_done & uv_sw_s;
      trips.uv_lin = armed & lin_done & uv_lin_s;
   end

   assign any_trip = |trips;
endmodule

// File: rtl/dual_rail_sequencer.sv
module dual_rail_sequencer
   import seqr_pkg::*;
#(
   parameter int NUM_STEPS   = 40,
   parameter int LEAD_STEPS  = 10,
   parameter int STEP_CYCLES = 32,
   parameter int SYNC_STAGES = 2,
   localparam int CODE_W     = $clog2(NUM_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              supply_ok,
   input  logic              enable,
   input  logic              oc_trip,
   input  logic              uv_sw_trip,
   input  logic              uv_lin_trip,
   output logic [CODE_W-1:0] sw_ref,
   output logic [CODE_W-1:0] lin_ref,
   output logic              hs_gate_en,
   output logic              ls_gate_en,
   output logic              lin_drv_en,
   output logic [2:0]        fault_flags
);
   localparam int N_IN = 5;

   if (NUM_STEPS < 1) begin : g_bad_num
      $error("dual_rail_sequencer: NUM_STEPS must be positive");
   end
   if (STEP_CYCLES < 1) begin : g_bad_step
      $error("dual_rail_sequencer: STEP_CYCLES must be positive");
   end
   if (LEAD_STEPS < 0 || LEAD_STEPS > NUM_STEPS) begin : g_bad_lead
      $error("dual_rail_sequencer: LEAD_STEPS out of range");
   end

   logic [N_IN-1:0] raw_in, syn_in;
   logic sup_s, en_s, oc_s, uvsw_s, uvlin_s;

   assign raw_in = {uv_lin_trip, uv_sw_trip, oc_trip, enable, supply_ok};

   seqr_sync_bank #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign {uvlin_s, uvsw_s, oc_s, en_s, sup_s} = syn_in;

   seq_state_e        state_q;
   trip_t             flags_q;
   trip_t             trips;
   logic              any_trip;
   logic              active;
   logic              sw_done, lin_done;
   logic [CODE_W-1:0] sw_code, lin_code;

   assign active = (state_q == ST_RAMP) || (state_q == ST_RUN);

   seqr_ramp_gen #(
      .NUM_STEPS   (NUM_STEPS),
      .LEAD_STEPS  (LEAD_STEPS),
      .STEP_CYCLES (STEP_CYCLES),
      .CODE_W      (CODE_W)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (!active),
      .advance  ((state_q == ST_RAMP) && osc_tick),
      .sw_code  (sw_code),
      .lin_code (lin_code),
      .sw_done  (sw_done),
      .lin_done (lin_done)
   );

   seqr_fault_mon u_fault (
      .armed    (active),
      .oc_s     (oc_s),
      .uv_sw_s  (uvsw_s),
      .uv_lin_s (uvlin_s),
      .sw_done  (sw_done),
      .lin_done (lin_done),
      .trips    (trips),
      .any_trip (any_trip)
   );

   // priority: supply loss, then shutdown, then faults, then ramp progress
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         flags_q <= '0;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               if (!sup_s) begin
                  flags_q <= '0;
               end else if (en_s) begin
                  state_q <= ST_RAMP;
                  flags_q <= '0;
               end
            end
            ST_RAMP, ST_RUN: begin
               if (!sup_s) begin
                  state_q <= ST_OFF;
                  flags_q <= '0;
               end else if (!en_s) begin
                  state_q <= ST_OFF;
               end else if (any_trip) begin
                  state_q <= ST_FAULT;
                  flags_q <= trips;
               end else if (state_q == ST_RAMP && lin_done) begin
                  state_q <= ST_RUN;
               end
            end
            ST_FAULT: begin
               if (!sup_s) begin
                  state_q <= ST_OFF;
                  flags_q <= '0;
               end else if (!en_s) begin
                  state_q <= ST_OFF;
               end
            end
            default: begin
               state_q <= ST_OFF;
               flags_q <= '0;
            end
         endcase
      end
   end

   assign sw_ref      = active ? sw_code  : '0;
   assign lin_ref     = active ? lin_code : '0;
   assign hs_gate_en  = active;
   assign ls_gate_en  = active;
   assign lin_drv_en  = active;
   assign fault_flags = flags_q;
endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
   parameter int NUM_STEPS  = 40,
   parameter int LEAD_STEPS = 10,
   parameter int CODE_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              supply_ok,
   input logic [CODE_W-1:0] sw_ref,
   input logic [CODE_W-1:0] lin_ref,
   input logic              hs_gate_en,
   input logic              ls_gate_en,
   input logic              lin_drv_en,
   input logic [2:0]        fault_flags
);
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_gate_en |-> (sw_ref == '0) && (lin_ref == '0) && !ls_gate_en && !lin_drv_en);

   p_sw_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sw_ref) |-> (sw_ref == $past(sw_ref) + 1'b1) || (sw_ref == '0));

   p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lin_ref) |-> (lin_ref == $past(lin_ref) + 1'b1) || (lin_ref == '0));

   p_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_ref != '0) |-> (int'(sw_ref) == NUM_STEPS) || (int'(sw_ref) == int'(lin_ref) + LEAD_STEPS));

   p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate_en) |-> (sw_ref == '0) && (lin_ref == '0));

   p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flags != 3'b000) |-> !hs_gate_en && !ls_gate_en && !lin_drv_en);

   p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flags != 3'b000) |=> (fault_flags == $past(fault_flags)) || (fault_flags == 3'b000));

   p_uv_sw_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flags[1]) |-> (int'($past(sw_ref)) == NUM_STEPS));

   p_uv_lin_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flags[2]) |-> (int'($past(lin_ref)) == NUM_STEPS));

   p_supply_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(supply_ok, 1) && !$past(supply_ok, 2) && !$past(supply_ok, 3))
         |-> !hs_gate_en && (fault_flags == 3'b000));
endmodule

bind dual_rail_sequencer seqr_checker #(
   .NUM_STEPS  (NUM_STEPS),
   .LEAD_STEPS (LEAD_STEPS),
   .CODE_W     (CODE_W)
) u_seqr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .supply_ok   (supply_ok),
   .sw_ref      (sw_ref),
   .lin_ref     (lin_ref),
   .hs_gate_en  (hs_gate_en),
   .ls_gate_en  (ls_gate_en),
   .lin_drv_en  (lin_drv_en),
   .fault_flags (fault_flags)
);

// File: tb/test_dual_rail_sequencer.sv
module test_dual_rail_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int N = 40;
   localparam int L = 10;
   localparam int S = 32;
   localparam int TOTAL = N + L;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_tick = 1'b0;
   logic supply_ok = 1'b0, enable = 1'b0;
   logic oc_trip = 1'b0, uv_sw_trip = 1'b0, uv_lin_trip = 1'b0;
   logic [5:0] sw_ref, lin_ref;
   logic hs_gate_en, ls_gate_en, lin_drv_en;
   logic [2:0] fault_flags;

   int n_chk = 0, n_fail = 0, cyc = 0, tick_div = 1;
   bit done = 0;

   dual_rail_sequencer i_dual_rail_sequencer (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .supply_ok(supply_ok),
      .enable(enable), .oc_trip(oc_trip), .uv_sw_trip(uv_sw_trip),
      .uv_lin_trip(uv_lin_trip), .sw_ref(sw_ref), .lin_ref(lin_ref),
      .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en), .lin_drv_en(lin_drv_en),
      .fault_flags(fault_flags)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      osc_tick <= ((cyc + 1) % tick_div) == 0;
   end

   // behavioural reference: 0 off, 1 ramping/running, 2 faulted
   int m_st, m_k, m_t;
   bit [2:0] m_flt;
   bit [4:0] m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_k = 0; m_t = 0; m_flt = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         bit sup, en;
         bit [2:0] tr;
         sup = m_s2[0]; en = m_s2[1];
         tr[0] = m_s2[2];
         tr[1] = m_s2[3] && (m_k >= N);
         tr[2] = m_s2[4] && (m_k == TOTAL);
         case (m_st)
            0: begin
               if (!sup) m_flt = 0;
               else if (en) begin m_st = 1; m_k = 0; m_t = 0; m_flt = 0; end
            end
            1: begin
               if (!sup) begin m_st = 0; m_flt = 0; end
               else if (!en) m_st = 0;
               else if (tr != 0) begin m_st = 2; m_flt = tr; end
               else if (osc_tick && m_k < TOTAL) begin
                  if (m_t == S - 1) begin m_t = 0; m_k++; end
                  else m_t++;
               end
            end
            default: begin
               if (!sup) begin m_st = 0; m_flt = 0; end
               else if (!en) m_st = 0;
            end
         endcase
         m_s2 = m_s1;
         m_s1 = {uv_lin_trip, uv_sw_trip, oc_trip, enable, supply_ok};
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e_sw, e_lin;
         e_sw  = (m_st == 1) ? ((m_k >= N) ? N : m_k) : 0;
         e_lin = (m_st == 1 && m_k > L) ? (m_k - L) : 0;
         chk("R3", "sw_ref", int'(sw_ref), e_sw);
         chk("R4", "lin_ref", int'(lin_ref), e_lin);
         chk("R5", "gates", int'({hs_gate_en, ls_gate_en, lin_drv_en}), (m_st == 1) ? 7 : 0);
         chk("R6", "fault_flags", int'(fault_flags), int'(m_flt));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_sw(int v);
      int n = 0;
      while (int'(sw_ref) != v && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic wait_lin(int v);
      int n = 0;
      while (int'(lin_ref) != v && n < 20000) begin @(negedge clk); n++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int c1, c2;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1", "reset sw_ref", int'(sw_ref), 0);
      chk("R1", "reset flags", int'(fault_flags), 0);

      supply_ok = 1'b1;
      wait_cyc(10);
      chk("R2", "gates without enable", int'(hs_gate_en), 0);
      enable = 1'b1;
      wait_cyc(2);
      chk("R1", "gate before 3rd edge", int'(hs_gate_en), 0);
      wait_cyc(1);
      chk("R1", "gate after 3rd edge", int'(hs_gate_en), 1);
      chk("R2", "start code", int'(sw_ref), 0);

      wait_sw(5);
      uv_sw_trip = 1'b1;
      wait_cyc(40);
      chk("R7", "masked uv_sw flags", int'(fault_flags), 0);
      chk("R7", "masked uv_sw gates", int'(hs_gate_en), 1);
      uv_sw_trip = 1'b0;

      wait_sw(N);
      c1 = cyc;
      uv_lin_trip = 1'b1;
      wait_cyc(20);
      chk("R8", "masked uv_lin flags", int'(fault_flags), 0);
      uv_lin_trip = 1'b0;
      wait_lin(N);
      c2 = cyc;
      chk("R4", "ramp lead cycles", c2 - c1, L * S);

      oc_trip = 1'b1;
      wait_cyc(1);
      oc_trip = 1'b0;
      wait_cyc(5);
      chk("R6", "oc flags", int'(fault_flags), 1);
      chk("R6", "oc gates", int'(ls_gate_en), 0);
      wait_cyc(30);
      chk("R9", "latched flags", int'(fault_flags), 1);
      chk("R9", "latched gates", int'(lin_drv_en), 0);

      enable = 1'b0;
      wait_cyc(10);
      chk("R10", "flags kept while disabled", int'(fault_flags), 1);
      enable = 1'b1;
      wait_cyc(3);
      chk("R10", "flags cleared on re-enable", int'(fault_flags), 0);
      chk("R10", "restart gates", int'(hs_gate_en), 1);
      chk("R10", "restart code", int'(sw_ref), 0);

      tick_div = 3;
      wait_sw(1);
      c1 = cyc;
      wait_sw(2);
      c2 = cyc;
      chk("R3", "step length with sparse ticks", c2 - c1, S * 3);
      wait_lin(N);
      tick_div = 1;

      uv_sw_trip = 1'b1;
      wait_cyc(5);
      chk("R7", "uv_sw flags", int'(fault_flags), 2);
      uv_sw_trip = 1'b0;

      supply_ok = 1'b0;
      wait_cyc(5);
      chk("R11", "flags cleared by supply loss", int'(fault_flags), 0);
      chk("R11", "gates off", int'(hs_gate_en), 0);
      supply_ok = 1'b1;
      wait_cyc(3);
      chk("R11", "restart gates", int'(hs_gate_en), 1);
      chk("R11", "restart code", int'(sw_ref), 0);

      wait_lin(N);
      uv_lin_trip = 1'b1;
      wait_cyc(5);
      chk("R8", "uv_lin flags", int'(fault_flags), 4);
      uv_lin_trip = 1'b0;

      enable = 1'b0;
      wait_cyc(5);
      enable = 1'b1;
      wait_cyc(3);
      wait_lin(N);
      oc_trip = 1'b1; uv_sw_trip = 1'b1; uv_lin_trip = 1'b1;
      wait_cyc(5);
      chk("R12", "simultaneous flags", int'(fault_flags), 7);
      oc_trip = 1'b0; uv_sw_trip = 1'b0; uv_lin_trip = 1'b0;

      enable = 1'b0;
      wait_cyc(5);
      enable = 1'b1;
      wait_sw(10);
      supply_ok = 1'b0;
      wait_cyc(5);
      chk("R11", "supply loss mid-ramp gates", int'(hs_gate_en), 0);
      chk("R11", "supply loss mid-ramp code", int'(sw_ref), 0);
      wait_cyc(5);
      finish_run();
   end
endmodule